// File: doc/BRIEF.md
# Dual-Address Conditional Breakpoint Unit

This unit watches the CPU bus one access at a time and compares it against two 24-bit breakpoint addresses. A 5-bit condition code picks the test. The code is a 3-bit condition class followed by a read-enable bit and a write-enable bit. The available tests are:

- an exact address match that also compares data;
- an address inside an inclusive range;
- an address outside a range;
- a match at either address;
- a two-step fetch sequence;
- mixed fetch and data tests;
- a stack-write guard.

When a test holds, the unit records which breakpoint fired and, for data breaks, whether the access was a read. It then raises a stall request towards the core.

Fetch breaks stall on the cycle after the matching fetch, which is before that instruction executes. Data breaks wait for the end of the current instruction. The stall holds until a release pulse arrives, and the release also clears the flags. Configuration goes through a small byte-wide write/read port.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, both breakpoint addresses read as all ones, the control byte reads 0, the status byte reads 0, and `stall_req`, `hit1`, `hit2` and `hit_rd` are low.
- R2: The config port maps its bytes as follows. Bytes 0..2 hold breakpoint A, least significant byte first. Bytes 3..5 hold breakpoint B in the same order. Byte 6 is the control byte: bits [4:2] are the condition class, bit 1 enables reads and bit 0 enables writes. Byte 7 is read-only status: bit0 hit1, bit1 hit2, bit2 hit_rd, bit3 stall, bit4 data break pending. Reads are combinational.
- R3: Access kinds are 0 fetch, 1 read, 2 write and 3 stack write; a stack write also counts as a write. Class 000 with a nonzero enable field fires hit1 when the address equals A, the data equals the low byte of B, and the access kind is enabled.
- R4: Class 001 fires hit1 when A <= address <= B. With enable field 00 the access must be a fetch; otherwise it must be an enabled read or write.
- R5: Class 010 fires hit1 when the address is <= A or >= B. The enable field is qualified in the same way as in R4.
- R6: Code 10000 is a sequence. A fetch at A arms the unit, and a later fetch at B while armed fires hit2 only. The armed state clears when the break fires or when any breakpoint or control byte is written.
- R7: Codes 10001..10011 fire on an enabled data access at A (hit1) and/or at B (hit2). Code 10100 does the same for fetches.
- R8: Codes 10101..10111 fire hit1 on a fetch at A and hit2 on an enabled data access at B.
- R9: Class 111 fires hit1 on a stack write at an address <= A. It fires hit2 at B on a fetch when the enable field is 00, and on an enabled data access otherwise.
- R10: Codes 00000, 011xx and 110xx never fire.
- R11: `hit_rd` is 1 for a data break caused by a read and 0 for a write or a fetch break.
- R12: A fetch counts only when `bus_insn_start` is high. A fetch break raises `stall_req` on the cycle after the access.
- R13: A data break records its flags at once, but it raises `stall_req` only on the cycle after `insn_end` is seen. That may be the same cycle as the access.
- R14: The stall and the flags hold until `stall_release`, and matches are ignored while a break is stalled or pending. The release drops the stall and clears all flags on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_addr | input | 3 | Config byte index |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data (combinational) |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 24 | Access address |
| bus_data | input | 8 | Access data |
| bus_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 stack write |
| bus_insn_start | input | 1 | Fetch address is a real instruction start |
| insn_end | input | 1 | Current instruction completes this cycle |
| stall_release | input | 1 | Release pulse from the debugger |
| stall_req | output | 1 | Stall request to the core |
| hit1 | output | 1 | Breakpoint A fired |
| hit2 | output | 1 | Breakpoint B fired |
| hit_rd | output | 1 | Data break was a read |

## Verification
The hardest states to reach from the ports are the armed sequence state and a data break pending with no instruction end yet. Neither is visible on the stall output until a later access or strobe arrives. The sweep runs every one of the 32 codes against a grid of addresses around both breakpoints, covering all access kinds and two data values. Because the armed bit carries across successive accesses within a code, the sequence mode is reached naturally, and a bench-side model keeps track of it. Directed steps then hold back `insn_end` to observe the pending state, drop `bus_insn_start` on a fetch, hit the second breakpoint while stalled, and rewrite a breakpoint byte between the two sequence fetches.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_STACK = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        C_EQDATA  = 3'd0,
        C_INSIDE  = 3'd1,
        C_OUTSIDE = 3'd2,
        C_OFF3    = 3'd3,
        C_EITHER  = 3'd4,
        C_MIXED   = 3'd5,
        C_OFF6    = 3'd6,
        C_STACK   = 3'd7
    } cond_e;

    typedef struct packed {
        logic [2:0] cond;
        logic       en_rd;
        logic       en_wr;
    } bk_ctrl_t;

    typedef struct packed {
        logic h1;
        logic h2;
        logic is_data;
        logic is_rd;
        logic arm;
    } hit_t;

    // enabled-data test: read with read enable, or write/stack write with write enable
    function automatic logic data_sel(input bk_ctrl_t c, input acc_kind_e k);
        return (c.en_rd && k == ACC_READ) ||
               (c.en_wr && (k == ACC_WRITE || k == ACC_STACK));
    endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8,
    parameter int RAW = 3,
    parameter int SW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    input  logic [SW-1:0]  status,
    output logic [DW-1:0]  rdata,
    output logic [AW-1:0]  bk_a,
    output logic [AW-1:0]  bk_b,
    output bk_ctrl_t       ctrl,
    output logic           touch
);
    localparam int NB = AW / DW;
    localparam int CTRL_IDX = 2 * NB;
    localparam int STAT_IDX = 2 * NB + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_a <= '1;
            bk_b <= '1;
            ctrl <= '0;
        end else if (we) begin
            for (int i = 0; i < NB; i++) begin
                if (addr == RAW'(i))      bk_a[i*DW +: DW] <= wdata;
                if (addr == RAW'(NB + i)) bk_b[i*DW +: DW] <= wdata;
            end
            if (addr == RAW'(CTRL_IDX)) ctrl <= bk_ctrl_t'(wdata[$bits(bk_ctrl_t)-1:0]);
        end
    end

    assign touch = we && (addr <= RAW'(CTRL_IDX));

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr == RAW'(i))      rdata = bk_a[i*DW +: DW];
            if (addr == RAW'(NB + i)) rdata = bk_b[i*DW +: DW];
        end
        if (addr == RAW'(CTRL_IDX)) rdata = DW'(ctrl);
        if (addr == RAW'(STAT_IDX)) rdata = DW'(status);
    end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input  bk_ctrl_t      ctrl,
    input  logic [AW-1:0] bk_a,
    input  logic [AW-1:0] bk_b,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  acc_kind_e     kind,
    input  logic          insn_start,
    input  logic          armed,
    output hit_t          hit
);
    logic fetch_ok, dsel, no_en, asel;
    logic eq_a, eq_b, in_rng, out_rng;

    always_comb begin
        fetch_ok = valid && kind == ACC_FETCH && insn_start;
        dsel     = valid && data_sel(ctrl, kind);
        no_en    = !ctrl.en_rd && !ctrl.en_wr;
        asel     = no_en ? fetch_ok : dsel;
        eq_a     = addr == bk_a;
        eq_b     = addr == bk_b;
        in_rng   = addr >= bk_a && addr <= bk_b;
        out_rng  = addr <= bk_a || addr >= bk_b;

        hit         = '0;
        hit.is_data = kind != ACC_FETCH;
        hit.is_rd   = kind == ACC_READ;
        unique case (cond_e'(ctrl.cond))
            C_EQDATA:  hit.h1 = !no_en && eq_a && data == bk_b[DW-1:0] && dsel;
            C_INSIDE:  hit.h1 = in_rng && asel;
            C_OUTSIDE: hit.h1 = out_rng && asel;
            C_EITHER: begin
                if (no_en) begin
                    hit.h2  = armed && fetch_ok && eq_b;
                    hit.arm = fetch_ok && eq_a && !hit.h2;
                end else begin
                    hit.h1 = eq_a && dsel;
                    hit.h2 = eq_b && dsel;
                end
            end
            C_MIXED: begin
                hit.h1 = fetch_ok && eq_a;
                hit.h2 = eq_b && (no_en ? fetch_ok : dsel);
            end
            C_STACK: begin
                hit.h1 = valid && kind == ACC_STACK && addr <= bk_a;
                hit.h2 = eq_b && (no_en ? fetch_ok : dsel);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
    import bkpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  hit_t hit,
    input  logic insn_end,
    input  logic release_i,
    input  logic cfg_touch,
    output logic stall,
    output logic pend,
    output logic f1,
    output logic f2,
    output logic frd,
    output logic armed
);
    logic idle, fire;

    assign idle = !stall && !pend;
    assign fire = idle && (hit.h1 || hit.h2);

    always_ff @(posedge clk) begin
        if (rst) begin
            stall <= 1'b0;
            pend  <= 1'b0;
            f1    <= 1'b0;
            f2    <= 1'b0;
            frd   <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (stall && release_i) begin
                stall <= 1'b0;
                f1    <= 1'b0;
                f2    <= 1'b0;
                frd   <= 1'b0;
            end else if (fire) begin
                f1  <= hit.h1;
                f2  <= hit.h2;
                frd <= hit.is_data && hit.is_rd;
                if (!hit.is_data || insn_end) stall <= 1'b1;
                else                          pend  <= 1'b1;
            end else if (pend && insn_end) begin
                pend  <= 1'b0;
                stall <= 1'b1;
            end

            if (cfg_touch || fire)     armed <= 1'b0;
            else if (idle && hit.arm)  armed <= 1'b1;
        end
    end
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [$clog2(2*(AW/DW)+2)-1:0]     cfg_addr,
    input  logic [DW-1:0]                      cfg_wdata,
    output logic [DW-1:0]                      cfg_rdata,
    input  logic                               bus_valid,
    input  logic [AW-1:0]                      bus_addr,
    input  logic [DW-1:0]                      bus_data,
    input  logic [1:0]                         bus_kind,
    input  logic                               bus_insn_start,
    input  logic                               insn_end,
    input  logic                               stall_release,
    output logic                               stall_req,
    output logic                               hit1,
    output logic                               hit2,
    output logic                               hit_rd
);
    localparam int RAW = $clog2(2 * (AW / DW) + 2);
    localparam int SW  = 5;

    logic [AW-1:0] bk_a, bk_b;
    bk_ctrl_t      ctrl;
    logic          touch, armed, pend;
    hit_t          hit;
    logic [SW-1:0] status;

    assign status = {pend, stall_req, hit_rd, hit2, hit1};

    bkpt_regs #(.AW(AW), .DW(DW), .RAW(RAW), .SW(SW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .status(status), .rdata(cfg_rdata), .bk_a(bk_a), .bk_b(bk_b),
        .ctrl(ctrl), .touch(touch)
    );

    bkpt_match #(.AW(AW), .DW(DW)) u_match (
        .ctrl(ctrl), .bk_a(bk_a), .bk_b(bk_b), .valid(bus_valid),
        .addr(bus_addr), .data(bus_data), .kind(acc_kind_e'(bus_kind)),
        .insn_start(bus_insn_start), .armed(armed), .hit(hit)
    );

    bkpt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .hit(hit), .insn_end(insn_end),
        .release_i(stall_release), .cfg_touch(touch),
        .stall(stall_req), .pend(pend), .f1(hit1), .f2(hit2), .frd(hit_rd),
        .armed(armed)
    );
endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk (
    input logic clk,
    input logic rst,
    input logic stall_release,
    input logic stall_req,
    input logic hit1,
    input logic hit2,
    input logic hit_rd
);
    // R14: stall persists until released
    p_stall_hold_r14: assert property (@(posedge clk) disable iff (rst)
        stall_req && !stall_release |=> stall_req);

    // R14: release drops the stall and all flags
    p_release_clears_r14: assert property (@(posedge clk) disable iff (rst)
        stall_req && stall_release |=> !stall_req && !hit1 && !hit2 && !hit_rd);

    // R14: flags frozen while stalled
    p_flags_frozen_r14: assert property (@(posedge clk) disable iff (rst)
        stall_req && !stall_release |=> $stable({hit1, hit2, hit_rd}));

    // R12: a stall always names at least one breakpoint
    p_stall_has_flag_r12: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> (hit1 || hit2));

    // R11: read flag only accompanies a recorded break
    p_rd_needs_hit_r11: assert property (@(posedge clk) disable iff (rst)
        hit_rd |-> (hit1 || hit2));
endmodule

bind bkpt_unit bkpt_unit_chk u_chk (
    .clk(clk), .rst(rst), .stall_release(stall_release),
    .stall_req(stall_req), .hit1(hit1), .hit2(hit2), .hit_rd(hit_rd)
);

// File: tb/sim_bkpt_unit.sv
`timescale 1ns/1ps
module sim_bkpt_unit;
    localparam logic [23:0] BA = 24'h000100;
    localparam logic [23:0] BB = 24'h000255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [1:0]  bus_kind = '0;
    logic        bus_insn_start = 1'b0;
    logic        insn_end = 1'b0;
    logic        stall_release = 1'b0;
    logic        stall_req, hit1, hit2, hit_rd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bkpt_unit u0 (.*);

    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_ck(input string tag, input logic [2:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        ck(tag, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic acc(input logic [23:0] a, input logic [1:0] k, input logic [7:0] d,
                       input logic st, input logic ie);
        bus_valid = 1'b1; bus_addr = a; bus_kind = k; bus_data = d;
        bus_insn_start = st; insn_end = ie;
        @(negedge clk);
        bus_valid = 1'b0; bus_insn_start = 1'b0; insn_end = 1'b0;
    endtask

    task automatic rel();
        stall_release = 1'b1;
        @(negedge clk);
        stall_release = 1'b0;
    endtask

    task automatic set_bk(input logic [23:0] a, input logic [23:0] b);
        for (int i = 0; i < 3; i++) wr(3'(i), a[i*8 +: 8]);
        for (int i = 0; i < 3; i++) wr(3'(3 + i), b[i*8 +: 8]);
    endtask

    // expected {rd, h2, h1} from the requirement text
    function automatic logic [2:0] model(input logic [4:0] c, input logic [23:0] a,
                                         input logic [1:0] k, input logic [7:0] d,
                                         input logic armed);
        logic f, ds, ne, h1, h2, sel;
        f  = (k == 2'd0);
        ds = (c[1] && k == 2'd1) || (c[0] && (k == 2'd2 || k == 2'd3));
        ne = (c[1:0] == 2'b00);
        sel = ne ? f : ds;
        h1 = 1'b0; h2 = 1'b0;
        case (c[4:2])
            3'd0: h1 = !ne && a == BA && d == BB[7:0] && ds;
            3'd1: h1 = a >= BA && a <= BB && sel;
            3'd2: h1 = (a <= BA || a >= BB) && sel;
            3'd4: if (ne) h2 = armed && f && a == BB;
                  else begin h1 = a == BA && ds; h2 = a == BB && ds; end
            3'd5: begin h1 = f && a == BA; h2 = a == BB && sel; end
            3'd7: begin h1 = k == 2'd3 && a <= BA; h2 = a == BB && sel; end
            default: ;
        endcase
        return {(h1 || h2) && k == 2'd1, h2, h1};
    endfunction

    function automatic string tag_of(input logic [4:0] c);
        case (c[4:2])
            3'd0: return (c[1:0] == 0) ? "R10" : "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd4: return (c[1:0] == 0) ? "R6" : "R7";
            3'd5: return (c[1:0] == 0) ? "R7" : "R8";
            3'd7: return "R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        logic [23:0] addrs [5];
        logic [7:0]  datas [2];
        addrs[0] = 24'h0000FF; addrs[1] = BA; addrs[2] = 24'h000180;
        addrs[3] = BB; addrs[4] = 24'h000300;
        datas[0] = 8'h55; datas[1] = 8'h12;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        ck("R1 stall", {31'h0, stall_req}, 0);
        ck("R1 flags", {29'h0, hit1, hit2, hit_rd}, 0);
        for (int i = 0; i < 6; i++) rd_ck("R1 bk byte", 3'(i), 8'hFF);
        rd_ck("R1 ctrl", 3'd6, 8'h00);
        rd_ck("R1 status", 3'd7, 8'h00);

        // R2 map and readback
        set_bk(BA, BB);
        rd_ck("R2 bkA lsb", 3'd0, 8'h00);
        rd_ck("R2 bkA mid", 3'd1, 8'h01);
        rd_ck("R2 bkB lsb", 3'd3, 8'h55);
        rd_ck("R2 bkB mid", 3'd4, 8'h02);
        wr(3'd6, 8'hFF);
        rd_ck("R2 ctrl width", 3'd6, 8'h1F);
        wr(3'd7, 8'hFF);
        rd_ck("R2 status read-only", 3'd7, 8'h00);

        // exhaustive code sweep
        for (int c = 0; c < 32; c++) begin
            logic armed;
            wr(3'd6, 8'(c));
            armed = 1'b0;
            for (int ai = 0; ai < 5; ai++)
                for (int k = 0; k < 4; k++)
                    for (int di = 0; di < 2; di++) begin
                        logic [2:0] e;
                        logic fire;
                        string t;
                        e = model(5'(c), addrs[ai], 2'(k), datas[di], armed);
                        fire = e[0] || e[1];
                        t = tag_of(5'(c));
                        acc(addrs[ai], 2'(k), datas[di], 1'b1, 1'b1);
                        if (fire) armed = 1'b0;
                        else if (c == 16 && k == 0 && addrs[ai] == BA) armed = 1'b1;
                        ck({t, " stall"}, {31'h0, stall_req}, {31'h0, fire});
                        ck({t, " hit1"}, {31'h0, hit1}, {31'h0, e[0]});
                        ck({t, " hit2"}, {31'h0, hit2}, {31'h0, e[1]});
                        ck("R11 hit_rd", {31'h0, hit_rd}, {31'h0, e[2]});
                        if (stall_req) begin
                            rel();
                            ck("R14 released", {28'h0, stall_req, hit1, hit2, hit_rd}, 0);
                        end
                    end
        end

        // R12 fetch needs instruction start, stalls next cycle
        wr(3'd6, 8'b00100);
        acc(24'h000180, 2'd0, 8'h0, 1'b0, 1'b0);
        ck("R12 no start", {31'h0, stall_req}, 0);
        acc(24'h000180, 2'd0, 8'h0, 1'b1, 1'b0);
        ck("R12 fetch stall", {31'h0, stall_req}, 1);
        rel();

        // R13 data break waits for instruction end
        wr(3'd6, 8'b00110);
        acc(24'h000180, 2'd1, 8'h0, 1'b0, 1'b0);
        ck("R13 pending no stall", {31'h0, stall_req}, 0);
        rd_ck("R13 pending status", 3'd7, 8'h15);
        repeat (2) @(negedge clk);
        ck("R13 still pending", {31'h0, stall_req}, 0);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        ck("R13 stall after end", {31'h0, stall_req}, 1);
        rel();

        // R14 matches ignored while stalled
        wr(3'd6, 8'b10011);
        acc(BA, 2'd2, 8'h0, 1'b0, 1'b1);
        ck("R14 first", {30'h0, hit2, hit1}, 1);
        acc(BB, 2'd1, 8'h0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        ck("R14 ignored", {29'h0, stall_req, hit2, hit1}, 3'b101);
        ck("R14 rd unchanged", {31'h0, hit_rd}, 0);
        rel();
        ck("R14 cleared", {29'h0, stall_req, hit2, hit1}, 0);

        // R6 config write drops the armed state
        wr(3'd6, 8'b10000);
        acc(BA, 2'd0, 8'h0, 1'b1, 1'b1);
        wr(3'd3, 8'h55);
        acc(BB, 2'd0, 8'h0, 1'b1, 1'b1);
        ck("R6 disarmed by write", {31'h0, stall_req}, 0);
        acc(BA, 2'd0, 8'h0, 1'b1, 1'b1);
        acc(24'h000180, 2'd0, 8'h0, 1'b1, 1'b1);
        acc(BB, 2'd0, 8'h0, 1'b1, 1'b1);
        ck("R6 sequence fires", {29'h0, stall_req, hit2, hit1}, 3'b110);
        rel();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule